// File: doc/BRIEF.md
# Serial Port with Split Baud Divisor

This block is a full-duplex asynchronous serial port for 8-bit frames with no parity and one stop bit. A host reaches it through a small register bus with a 2-bit address, separate read and write strobes and byte-wide data. Through that bus the host loads the baud divisor, writes bytes to transmit, reads bytes received and polls a line status register.

The bit timing comes from a 16-bit divisor kept in two byte-wide latches. A tick generator pulses once every divisor clock cycles. Each serial bit lasts sixteen ticks, so the line rate is the clock frequency divided by 16 × (256 × high + low). Both directions are single-buffered. One transmit holding register feeds a shift register. One receive buffer keeps the oldest unread byte. When a second byte arrives before the first is read, the new byte is discarded and an overrun flag is raised.

Register map: address 0 reads the receive buffer and writes the transmit holding register. Address 1 is the low divisor latch, address 2 is the high divisor latch, and address 3 is the line status register.

Top module: `uart_dl`

## Requirements
- R1: Address 1 holds divisor bits [7:0] and address 2 holds divisor bits [15:8]. Both can be written and read back. After reset they hold 1 and 0.
- R2: Every serial bit lasts 16 × (256 × high + low) clock cycles, in both directions.
- R3: txd idles at 1. A frame is one start bit at 0, eight data bits with the LSB first, and one stop bit at 1.
- R4: Line status bit 5 (transmit holding empty) is 1 after reset. It reads 0 from the cycle after a write to address 0 until the byte moves into the transmit shift register.
- R5: The receiver samples the start bit at its middle (tick 8), then samples each data bit at mid-bit with the LSB first. A good frame puts the byte in the receive buffer (address 0) and sets line status bit 0 (data ready).
- R6: Reading address 0 clears line status bit 0.
- R7: A byte that completes while bit 0 is still set is dropped. The buffer keeps the older byte and line status bit 1 (overrun) is set. Reading the line status register clears bit 1.
- R8: A divisor of 0 acts as a divisor of 1.
- R9: A low pulse on rxd shorter than half a bit does not start a frame and leaves bit 0 clear.
- R10: A frame whose stop bit samples 0 is discarded and leaves bit 0 clear.
- R11: The line status register is read-only: bits 0, 1 and 5 as above, every other bit 0. Writes to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the baud reference |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; a read clears status at the clock edge that ends the cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, valid in the same cycle |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line, asynchronous |

## Verification
The transmitter is exercised with the bytes 0xA5, 0x5A and 0xC3 at divisors 2, 0 and 256. Alternating and clustered bit patterns expose a reversed bit order or a wrong bit period. The divisor-256 case shows whether the high latch takes part in the division at all. The receiver is given a clean byte, then two back-to-back bytes with no read between them, which tells keep-oldest apart from keep-newest on overrun. It is also given a short low glitch and a frame with a low stop bit, each of which must leave data ready clear.

// File: rtl/uart_dl.sv
module uart_dl #(
  parameter int OVERSAMPLE = 16,
  parameter int DIV_W      = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       txd,
  input  logic       rxd
);
  localparam int OSW = $clog2(OVERSAMPLE);
  localparam logic [OSW-1:0] OS_LAST = OSW'(OVERSAMPLE - 1);
  localparam logic [OSW-1:0] OS_MID  = OSW'(OVERSAMPLE / 2 - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_t;

  logic [7:0] div_lo, div_hi;
  logic [DIV_W-1:0] div_raw, div_eff, bcnt;
  logic tick;

  wire wr_thr = bus_wr && bus_addr == 2'd0;
  wire wr_lo  = bus_wr && bus_addr == 2'd1;
  wire wr_hi  = bus_wr && bus_addr == 2'd2;
  wire rd_rbr = bus_rd && bus_addr == 2'd0;
  wire rd_lsr = bus_rd && bus_addr == 2'd3;

  assign div_raw = DIV_W'({div_hi, div_lo});
  assign div_eff = (div_raw == '0) ? DIV_W'(1) : div_raw;
  assign tick    = (bcnt == div_eff - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_lo <= 8'd1;
      div_hi <= 8'd0;
      bcnt   <= '0;
    end else begin
      if (wr_lo) div_lo <= bus_wdata;
      if (wr_hi) div_hi <= bus_wdata;
      if (wr_lo || wr_hi || tick) bcnt <= '0;
      else                        bcnt <= bcnt + DIV_W'(1);
    end
  end

  logic [7:0]     thr;
  logic           thr_full;
  logic [9:0]     tx_sh;
  logic           tx_busy;
  logic [OSW-1:0] tx_os;
  logic [3:0]     tx_bits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr      <= '0;
      thr_full <= 1'b0;
      tx_sh    <= '1;
      tx_busy  <= 1'b0;
      tx_os    <= '0;
      tx_bits  <= '0;
    end else begin
      if (tick) begin
        if (!tx_busy) begin
          if (thr_full) begin
            tx_sh    <= {1'b1, thr, 1'b0};
            tx_bits  <= 4'd10;
            tx_os    <= '0;
            tx_busy  <= 1'b1;
            thr_full <= 1'b0;
          end
        end else begin
          tx_os <= tx_os + 1'b1;
          if (tx_os == OS_LAST) begin
            tx_sh   <= {1'b1, tx_sh[9:1]};
            tx_bits <= tx_bits - 4'd1;
            if (tx_bits == 4'd1) tx_busy <= 1'b0;
          end
        end
      end
      if (wr_thr) begin
        thr      <= bus_wdata;
        thr_full <= 1'b1;
      end
    end
  end

  assign txd = tx_busy ? tx_sh[0] : 1'b1;

  logic           rx_s1, rx_s2;
  rx_st_t         rx_st;
  logic [OSW-1:0] rx_os;
  logic [2:0]     rx_n;
  logic [7:0]     rx_sh, rbr;
  logic           rx_ready, rx_ovr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_s1    <= 1'b1;
      rx_s2    <= 1'b1;
      rx_st    <= RX_IDLE;
      rx_os    <= '0;
      rx_n     <= '0;
      rx_sh    <= '0;
      rbr      <= '0;
      rx_ready <= 1'b0;
      rx_ovr   <= 1'b0;
    end else begin
      rx_s1 <= rxd;
      rx_s2 <= rx_s1;
      if (rd_rbr) rx_ready <= 1'b0;
      if (rd_lsr) rx_ovr   <= 1'b0;
      if (tick) begin
        unique case (rx_st)
          RX_IDLE: if (!rx_s2) begin
            rx_st <= RX_START;
            rx_os <= '0;
          end
          RX_START: if (rx_os == OS_MID) begin
            rx_os <= '0;
            rx_n  <= '0;
            rx_st <= rx_s2 ? RX_IDLE : RX_DATA;
          end else rx_os <= rx_os + 1'b1;
          RX_DATA: if (rx_os == OS_LAST) begin
            rx_os <= '0;
            rx_sh <= {rx_s2, rx_sh[7:1]};
            rx_n  <= rx_n + 3'd1;
            if (rx_n == 3'd7) rx_st <= RX_STOP;
          end else rx_os <= rx_os + 1'b1;
          RX_STOP: if (rx_os == OS_LAST) begin
            rx_st <= RX_IDLE;
            if (rx_s2) begin
              if (rx_ready && !rd_rbr) rx_ovr <= 1'b1;
              else begin
                rbr      <= rx_sh;
                rx_ready <= 1'b1;
              end
            end
          end else rx_os <= rx_os + 1'b1;
          default: rx_st <= RX_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (bus_addr)
      2'd0: bus_rdata = rbr;
      2'd1: bus_rdata = div_lo;
      2'd2: bus_rdata = div_hi;
      default: bus_rdata = {2'b00, ~thr_full, 3'b000, rx_ovr, rx_ready};
    endcase
  end
endmodule

// File: rtl/uart_dl_chk.sv
module uart_dl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  bus_addr,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic        txd,
  input logic        tx_busy,
  input logic        thr_full,
  input logic        ready,
  input logic        overrun,
  input logic        rx_idle,
  input logic [15:0] div_raw,
  input logic        tick
);
  AST_TXD_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd); // R3
  AST_THR_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0) |=> thr_full); // R4
  AST_RBR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 2'd0 && rx_idle) |=> !ready); // R6
  AST_OVERRUN_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(ready)); // R7
  AST_ZERO_DIV_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (div_raw == 16'd0 && $stable(div_raw)) |-> tick); // R8
endmodule

bind uart_dl uart_dl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .txd(txd), .tx_busy(tx_busy), .thr_full(thr_full), .ready(rx_ready),
  .overrun(rx_ovr), .rx_idle(rx_st == RX_IDLE), .div_raw(div_raw), .tick(tick)
);

// File: tb/uart_dl_tb.sv
module uart_dl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic txd;
  logic rxd = 1'b1;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_dl u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .txd(txd), .rxd(rxd));

  task automatic chk(input string tag, input int got, input int exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic tx_expect(input string tag, input logic [7:0] b, input int p);
    int waited = 0;
    while (txd !== 1'b0 && waited < 4 * p) begin
      @(negedge clk); waited++;
    end
    repeat (p / 2) @(negedge clk);
    chk({tag, " start bit"}, txd, 0);
    for (int i = 0; i < 8; i++) begin
      repeat (p) @(negedge clk);
      chk($sformatf("%s data bit %0d", tag, i), txd, b[i]);
    end
    repeat (p) @(negedge clk);
    chk({tag, " stop bit"}, txd, 1);
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stopv, input int p, input int stop_len);
    rxd = 1'b0;
    repeat (p) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (p) @(negedge clk);
    end
    rxd = stopv;
    repeat (stop_len) @(negedge clk);
    rxd = 1'b1;
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(2'd3, d); chk("R11 reset status", d, 8'h20);
    rd(2'd1, d); chk("R1 reset low latch", d, 8'h01);
    rd(2'd2, d); chk("R1 reset high latch", d, 8'h00);
    chk("R3 idle line", txd, 1);

    wr(2'd1, 8'h02); wr(2'd2, 8'h00);
    rd(2'd1, d); chk("R1 low readback", d, 8'h02);
    rd(2'd2, d); chk("R1 high readback", d, 8'h00);

    wr(2'd0, 8'hA5);
    rd(2'd3, d); chk("R4 holding full after write", d, 8'h00);
    tx_expect("R3 R2 byte A5 div 2", 8'hA5, 32);
    rd(2'd3, d); chk("R4 holding empty again", d, 8'h20);
    repeat (64) @(negedge clk);

    send_rx(8'h3C, 1'b1, 32, 32);
    rd(2'd3, d); chk("R5 data ready", d, 8'h21);
    rd(2'd0, d); chk("R5 received byte", d, 8'h3C);
    rd(2'd3, d); chk("R6 ready cleared by read", d, 8'h20);

    send_rx(8'h81, 1'b1, 32, 32);
    send_rx(8'h7E, 1'b1, 32, 32);
    rd(2'd3, d); chk("R7 overrun flagged", d, 8'h23);
    rd(2'd0, d); chk("R7 oldest byte kept", d, 8'h81);
    rd(2'd3, d); chk("R7 overrun cleared by status read", d, 8'h20);

    rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    repeat (400) @(negedge clk);
    rd(2'd3, d); chk("R9 glitch rejected", d, 8'h20);

    send_rx(8'h55, 1'b0, 32, 24);
    repeat (400) @(negedge clk);
    rd(2'd3, d); chk("R10 bad stop discarded", d, 8'h20);

    wr(2'd3, 8'hFF);
    rd(2'd3, d); chk("R11 status write ignored", d, 8'h20);

    wr(2'd1, 8'h00);
    rd(2'd1, d); chk("R1 low latch zero", d, 8'h00);
    wr(2'd0, 8'h5A);
    tx_expect("R8 divisor zero as one", 8'h5A, 16);
    repeat (32) @(negedge clk);

    wr(2'd2, 8'h01);
    rd(2'd2, d); chk("R1 high latch", d, 8'h01);
    wr(2'd0, 8'hC3);
    tx_expect("R2 divisor 256", 8'hC3, 4096);
    repeat (4096) @(negedge clk);
    chk("R3 idle after frame", txd, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule